// File: doc/BRIEF.md
# Paged Coefficient Write Interface

This block sits between a narrow control bus and the coefficient memories of a bank of filter instances. Each filter instance owns two 32-word banks of 18-bit coefficients: bank 0 holds coefficients 0 to 31 and bank 1 holds coefficients 32 to 63, both addressed from word 0. The bus offers only a 6-bit address and a 16-bit data word. An 18-bit coefficient therefore reaches its memory in two writes: one carries the upper 16 bits and the other the lower 2 bits.

A page register at bus address 0x21 picks the target of the writes that follow. It names the filter instance, the bank and the field (upper or lower). Bus addresses 0x00 to 0x1F then name a word of the selected bank directly. Each accepted write becomes one registered pulse on a single memory write enable, together with the word address, the positioned data and a bit mask. The mask lets the memory update only the chosen field and keep the other field.

Top module: `cpw_coef_loader`

## Requirements
- R1: A strobed write to address 0x21 loads all 16 data bits into the page register. The new page governs every later strobe, starting with the very next cycle. The page write itself raises no memory write enable.
- R2: After reset the page register holds 0x007F, which selects no target. Writes to word addresses before the first page write raise no write enable.
- R3: Page encoding, fixed bit positions:
  - bit 7 selects the field (0 = upper 16 bits, 1 = lower 2 bits).
  - bit 8 selects the bank.
  - bits [11:9] hold the instance number.
  - The page selects a target only when bits [6:0] and [15:12] are all zero and the instance is below NUM_INST.
  - Example: 0x0480 selects the lower field of bank 0 of instance 2.
- R4: A strobed write to an address 0x00 to 0x1F under a page that selects a target gives exactly one active enable one cycle later, for exactly one cycle. The enable is bit `coef_we[inst*2+bank]`, and `coef_addr` equals the bus address.
- R5: An upper-field write presents `coef_wdata[17:2]` = bus data, `coef_wdata[1:0]` = 0, and `coef_wmask` = 0x3FFFC.
- R6: A lower-field write presents `coef_wdata[1:0]` = bus data bits [1:0], all other data bits 0, and `coef_wmask` = 0x00003. Bus data bits [15:2] are ignored.
- R7: Strobed writes to 0x20 and 0x22 to 0x3F raise no write enable and leave the page register unchanged.
- R8: In a cycle that follows no strobe, every write enable is low.
- R9: A memory that applies each write through its mask holds the full 18-bit coefficient after both of its writes, in either order. Coefficient n lands in bank n/32 at word n mod 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | 6 | Bus word address |
| bus_wdata | input | 16 | Bus write data |
| coef_we | output | NUM_INST*2 | One write enable per instance and bank, index inst*2+bank |
| coef_addr | output | 5 | Word address within the selected bank |
| coef_wdata | output | 18 | Coefficient data with the active field in place |
| coef_wmask | output | 18 | Bit mask of the coefficient bits to update |

## Verification
The bench builds the block with NUM_INST = 3. This leaves instance codes 3 to 7 of the 3-bit page field out of range, so the rejection of an absent instance is exercised next to the normal case. Under that configuration, every instance, bank and field combination is swept against all 64 bus addresses. Pages with stray bits in the reserved ranges are also tried. A bench-side masked memory then checks that full coefficients, written in both field orders across both banks, come back whole.

// File: rtl/cpw_pkg.sv
package cpw_pkg;

  localparam int PAGE_FIELD_BIT = 7;
  localparam int PAGE_BANK_BIT  = 8;
  localparam int PAGE_INST_LSB  = 9;
  localparam int PAGE_INST_W    = 3;
  localparam int PAGE_LOW_W     = 7;
  localparam int PAGE_TOP_LSB   = PAGE_INST_LSB + PAGE_INST_W;
  localparam int PAGE_RESET_VAL = 'h007F;

  typedef struct packed {
    logic                   valid;
    logic [PAGE_INST_W-1:0] inst;
    logic                   bank;
    logic                   lsb;
  } page_sel_t;

endpackage

// File: rtl/cpw_rst_sync.sv
module cpw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/cpw_page_reg.sv
module cpw_page_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_stb,
  input  logic [DATA_W-1:0] page_data,
  output logic [DATA_W-1:0] page_q
);
  import cpw_pkg::*;

  localparam logic [DATA_W-1:0] RESET_PAGE = DATA_W'(PAGE_RESET_VAL);

  logic [DATA_W-1:0] page_d;
  logic              page_en;

  assign page_en = page_stb;

  always_comb begin
    page_d = page_q;
    if (page_en) begin
      page_d = page_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= RESET_PAGE;
    end else begin
      page_q <= page_d;
    end
  end

  // R7 / R1: page only changes on its own strobe, and then to the bus data
  a_r7_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !page_stb |=> $stable(page_q));
  a_r1_page_load: assert property (@(posedge clk) disable iff (!rst_n)
    page_stb |=> page_q == $past(page_data));

endmodule

// File: rtl/cpw_page_decode.sv
module cpw_page_decode #(
  parameter int DATA_W   = 16,
  parameter int NUM_INST = 8
) (
  input  logic [DATA_W-1:0]    page_q,
  output cpw_pkg::page_sel_t   sel
);
  import cpw_pkg::*;

  logic low_clear;
  logic top_clear;
  logic inst_ok;

  always_comb begin
    low_clear = (page_q[PAGE_LOW_W-1:0] == '0);
    top_clear = (page_q[DATA_W-1:PAGE_TOP_LSB] == '0);
    sel.inst  = page_q[PAGE_INST_LSB +: PAGE_INST_W];
    sel.bank  = page_q[PAGE_BANK_BIT];
    sel.lsb   = page_q[PAGE_FIELD_BIT];
    inst_ok   = (int'(sel.inst) < NUM_INST);
    sel.valid = low_clear && top_clear && inst_ok;
  end

endmodule

// File: rtl/cpw_write_fmt.sv
module cpw_write_fmt #(
  parameter int NUM_INST = 8,
  parameter int WORD_AW  = 5,
  parameter int DATA_W   = 16,
  parameter int COEF_W   = 18,
  parameter int LSB_W    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  word_stb,
  input  logic [WORD_AW-1:0]    word_addr,
  input  logic [DATA_W-1:0]     word_data,
  input  cpw_pkg::page_sel_t    sel,
  output logic [NUM_INST*2-1:0] coef_we,
  output logic [WORD_AW-1:0]    coef_addr,
  output logic [COEF_W-1:0]     coef_wdata,
  output logic [COEF_W-1:0]     coef_wmask
);

  localparam int NUM_WE = NUM_INST * 2;
  localparam int HI_W   = COEF_W - LSB_W;
  localparam logic [COEF_W-1:0] LO_MASK = COEF_W'((1 << LSB_W) - 1);
  localparam logic [COEF_W-1:0] HI_MASK = ~LO_MASK;

  logic              load_en;
  logic [NUM_WE-1:0] we_d;
  logic [WORD_AW-1:0] addr_d;
  logic [COEF_W-1:0] wdata_d;
  logic [COEF_W-1:0] wmask_d;
  logic [COEF_W-1:0] field_data;
  logic [COEF_W-1:0] field_mask;

  assign load_en = word_stb && sel.valid;

  for (genvar g = 0; g < NUM_WE; g++) begin : g_we
    assign we_d[g] = load_en && ((int'(sel.inst) * 2 + int'(sel.bank)) == g);
  end

  always_comb begin
    if (sel.lsb) begin
      field_data = {{HI_W{1'b0}}, word_data[LSB_W-1:0]};
      field_mask = LO_MASK;
    end else begin
      field_data = {word_data[HI_W-1:0], {LSB_W{1'b0}}};
      field_mask = HI_MASK;
    end
  end

  always_comb begin
    addr_d  = coef_addr;
    wdata_d = coef_wdata;
    wmask_d = coef_wmask;
    if (load_en) begin
      addr_d  = word_addr;
      wdata_d = field_data;
      wmask_d = field_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_we    <= '0;
      coef_addr  <= '0;
      coef_wdata <= '0;
      coef_wmask <= '0;
    end else begin
      coef_we    <= we_d;
      coef_addr  <= addr_d;
      coef_wdata <= wdata_d;
      coef_wmask <= wmask_d;
    end
  end

  // R4: one enable, address follows the bus
  a_r4_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> ($onehot(coef_we) && coef_addr == $past(word_addr)));
  a_r4_never_multi: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(coef_we));
  // R8: no strobe, no enable
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |=> coef_we == '0);
  // R5: upper field placement
  a_r5_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !sel.lsb) |=> (coef_wmask == HI_MASK &&
      coef_wdata == {$past(word_data[HI_W-1:0]), {LSB_W{1'b0}}}));
  // R6: lower field placement
  a_r6_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && sel.lsb) |=> (coef_wmask == LO_MASK &&
      coef_wdata == {{HI_W{1'b0}}, $past(word_data[LSB_W-1:0])}));

endmodule

// File: rtl/cpw_coef_loader.sv
module cpw_coef_loader #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int COEF_W     = 18,
  parameter int LSB_W      = 2,
  parameter int BANK_DEPTH = 32,
  parameter int NUM_INST   = 8,
  parameter int PAGE_ADDR  = 'h21
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [NUM_INST*2-1:0] coef_we,
  output logic [$clog2(BANK_DEPTH)-1:0] coef_addr,
  output logic [COEF_W-1:0]     coef_wdata,
  output logic [COEF_W-1:0]     coef_wmask
);

  localparam int WORD_AW = $clog2(BANK_DEPTH);
  localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(BANK_DEPTH - 1);
  localparam logic [ADDR_W-1:0] PAGE_A    = ADDR_W'(PAGE_ADDR);

  logic               rst_sync_n;
  logic               page_stb;
  logic               word_stb;
  logic [DATA_W-1:0]  page_q;
  cpw_pkg::page_sel_t sel;

  cpw_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign page_stb = bus_we && (bus_addr == PAGE_A);
  assign word_stb = bus_we && (bus_addr <= LAST_WORD);

  cpw_page_reg #(.DATA_W(DATA_W)) u_page_reg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .page_stb  (page_stb),
    .page_data (bus_wdata),
    .page_q    (page_q)
  );

  cpw_page_decode #(.DATA_W(DATA_W), .NUM_INST(NUM_INST)) u_decode (
    .page_q (page_q),
    .sel    (sel)
  );

  cpw_write_fmt #(
    .NUM_INST (NUM_INST),
    .WORD_AW  (WORD_AW),
    .DATA_W   (DATA_W),
    .COEF_W   (COEF_W),
    .LSB_W    (LSB_W)
  ) u_fmt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .word_stb   (word_stb),
    .word_addr  (bus_addr[WORD_AW-1:0]),
    .word_data  (bus_wdata),
    .sel        (sel),
    .coef_we    (coef_we),
    .coef_addr  (coef_addr),
    .coef_wdata (coef_wdata),
    .coef_wmask (coef_wmask)
  );

  // R7: addresses outside the word window give no enable
  a_r7_unmapped: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_addr > LAST_WORD) |=> coef_we == '0);

endmodule

// File: tb/cpw_coef_loader_tb.sv
module cpw_coef_loader_tb;

  localparam int NI  = 3;
  localparam int NWE = NI * 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [5:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [NWE-1:0] coef_we;
  logic [4:0]  coef_addr;
  logic [17:0] coef_wdata;
  logic [17:0] coef_wmask;

  int checks = 0;
  int fails  = 0;
  logic [15:0] cur_page;
  logic [17:0] mem [0:NWE-1][0:31];

  always #2.5 clk = ~clk;

  cpw_coef_loader #(.NUM_INST(NI)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_wdata(coef_wdata), .coef_wmask(coef_wmask)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] coef_val(input int k);
    return 18'((k * 7919 + 12345) ^ (k << 11));
  endfunction

  task automatic apply_mem();
    for (int g = 0; g < NWE; g++) begin
      if (coef_we[g]) mem[g][coef_addr] = (mem[g][coef_addr] & ~coef_wmask) | (coef_wdata & coef_wmask);
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    check(coef_we == '0, "R8 idle", 32'(coef_we), 0);
  endtask

  task automatic page_write(input logic [15:0] p);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 6'h21; bus_wdata = p;
    @(negedge clk);
    bus_we = 1'b0;
    cur_page = p;
    check(coef_we == '0, "R1 page write no enable", 32'(coef_we), 0);
  endtask

  task automatic word_write(input logic [5:0] a, input logic [15:0] d);
    logic valid;
    int   inst;
    int   idx;
    logic [NWE-1:0] exp_we;
    logic [17:0] exp_data;
    logic [17:0] exp_mask;
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    inst  = int'(cur_page[11:9]);
    valid = (cur_page[6:0] == 0) && (cur_page[15:12] == 0) && (inst < NI);
    idx   = inst * 2 + int'(cur_page[8]);
    exp_we = '0;
    if (valid && a < 6'd32) exp_we[idx] = 1'b1;
    if (cur_page[7]) begin
      exp_data = {16'h0, d[1:0]}; exp_mask = 18'h00003;
    end else begin
      exp_data = {d, 2'b00};      exp_mask = 18'h3FFFC;
    end
    check(coef_we == exp_we, "R3/R4/R7 enable select", 32'(coef_we), 32'(exp_we));
    if (exp_we != '0) begin
      check(coef_addr == a[4:0], "R4 word address", 32'(coef_addr), 32'(a[4:0]));
      check(coef_wdata == exp_data && coef_wmask == exp_mask,
            cur_page[7] ? "R6 lower field" : "R5 upper field",
            {coef_wmask[15:0], coef_wdata[15:0]}, {exp_mask[15:0], exp_data[15:0]});
    end
    apply_mem();
    idle_check();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    cur_page = 16'h007F;
    for (int g = 0; g < NWE; g++) for (int w = 0; w < 32; w++) mem[g][w] = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(coef_we == '0 && coef_wmask == '0, "R2 reset outputs", 32'(coef_we), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: no page written yet, nothing may be enabled
    for (int a = 0; a < 32; a++) word_write(6'(a), 16'(a * 37 + 5));

    // R3/R4/R5/R6/R7: every page target against every bus address
    for (int ins = 0; ins < 8; ins++)
      for (int bk = 0; bk < 2; bk++)
        for (int fl = 0; fl < 2; fl++) begin
          page_write({4'h0, 3'(ins), 1'(bk), 1'(fl), 7'h00});
          for (int a = 0; a < 64; a++)
            if (a != 'h21) word_write(6'(a), 16'(a * 613 + ins * 97 + bk * 41 + fl * 11 + 4660));
        end

    // R3: the documented example page 0x0480
    page_write(16'h0480);
    word_write(6'h05, 16'hFFFE);
    check(mem[4][5][1:0] == 2'b10, "R3 page 0x0480 lower bank0 inst2",
          32'(mem[4][5][1:0]), 32'h2);

    // R3: a stray bit in a reserved range selects nothing
    for (int b = 0; b < 16; b++)
      if (b < 7 || b > 11) begin
        page_write(16'h0200 | (16'h1 << b));
        word_write(6'h03, 16'hBEEF);
        word_write(6'h1F, 16'h1234);
      end

    // R7: page survives unmapped writes
    page_write(16'h0300);
    word_write(6'h20, 16'hAAAA);
    word_write(6'h3F, 16'h5555);
    word_write(6'h07, 16'h0F0F);
    check(coef_we == '0, "R7 page kept", 32'(coef_we), 0);

    // R9: full coefficients, both banks, upper-then-lower and lower-then-upper
    for (int bk = 0; bk < 2; bk++) begin
      if (bk == 0) begin
        page_write(16'h0200);
        for (int w = 0; w < 32; w++) word_write(6'(w), coef_val(w)[17:2]);
        page_write(16'h0280);
        for (int w = 0; w < 32; w++) word_write(6'(w), {14'h3FFF, coef_val(w)[1:0]});
      end else begin
        page_write(16'h0380);
        for (int w = 0; w < 32; w++) word_write(6'(w), {14'h2AAA, coef_val(32 + w)[1:0]});
        page_write(16'h0300);
        for (int w = 0; w < 32; w++) word_write(6'(w), coef_val(32 + w)[17:2]);
      end
    end
    for (int k = 0; k < 64; k++)
      check(mem[2 + k / 32][k % 32] == coef_val(k), "R9 coefficient rebuilt",
            32'(mem[2 + k / 32][k % 32]), 32'(coef_val(k)));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule